// File: doc/BRIEF.md
# Super I/O index/data configuration port

This block gives a host processor access to a 256-byte configuration space through two byte-wide I/O locations. The host first writes a register number to the index location. Reads and writes at the data location then reach the configuration byte that the index selects. The index stays put across any number of data accesses, so one index write can be followed by several reads, or by a read-modify-write, of the same byte.

Each configuration byte has a fixed write policy, set by its register number. Reserved and unsupported registers never change. Two base-address registers accept only one permitted value, and every other value written to them is dropped without notice. All remaining registers take any byte. The port responds only while an enable input from the host bridge is high. That input is low out of reset in the system, so the port stays invisible until software turns it on.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the index is 0x00. Configuration bytes 0xE0, 0xE2, 0xE3, 0xE6, 0xE7 and 0xE8 hold 0x3C, 0x03, 0xFC, 0xDE, 0xFE and 0xBE. Every other byte holds 0x00.
- R2: While the port is enabled, a write to the index address (default 0x3F0) stores io_wdata as the current index. The new index takes effect from the next clock edge.
- R3: While the port is enabled, a read strobe at the data address (default 0x3F1) drives io_rdata, in the same cycle, with the configuration byte that the current index selects. A read never changes the index or any configuration byte.
- R4: A data-port write to index 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF leaves the selected byte unchanged.
- R5: A data-port write to index 0xE7 is stored only when the value is 0xFE. A data-port write to index 0xE8 is stored only when the value is 0xBE. Any other value leaves the byte unchanged.
- R6: A data-port write to any other index (for example 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4) stores the written byte from the next clock edge.
- R7: While port_en is low, io_rdata is 0xFF and writes change neither the index nor any configuration byte.
- R8: Accesses to any address other than the index and data addresses have no effect, and reads there return 0xFF. io_rdata is also 0xFF whenever io_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Decode enable from the bridge configuration bit |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Single-cycle byte write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, 0xFF when not claimed |

## Verification
On every cycle the assertions check four things: disabled or unclaimed reads return 0xFF, the index follows index-port writes and holds otherwise, locked and keyed bytes keep their value when a rejected write arrives, and open bytes take the written value one edge later. Other behaviour shows only in the bench scenarios. These cover the full reset image of all 256 bytes, interleaved sequences in which one index serves several data accesses, and random mixes of enable toggles, stray addresses and policy classes compared against a reference model.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned IDX_W    = 8;
    localparam int unsigned NUM_REGS = 1 << IDX_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [1:0] {
        WP_OPEN   = 2'd0,
        WP_LOCKED = 2'd1,
        WP_KEYED  = 2'd2
    } wp_class_e;

    typedef struct packed {
        logic idx_wr;
        logic data_wr;
        logic data_rd;
    } io_strobe_t;

    function automatic wp_class_e wp_class(idx_t idx);
        wp_class_e c;
        if (idx <= 8'hDF) begin
            c = WP_LOCKED;
        end else begin
            case (idx) inside
                8'hE4, 8'hE5,
                [8'hE9:8'hED],
                8'hF3, 8'hF5, 8'hF7,
                [8'hF9:8'hFB],
                [8'hFD:8'hFF]:  c = WP_LOCKED;
                8'hE7, 8'hE8:   c = WP_KEYED;
                default:        c = WP_OPEN;
            endcase
        end
        return c;
    endfunction

    function automatic byte_t key_value(idx_t idx);
        byte_t v;
        case (idx)
            8'hE7:   v = 8'hFE;
            8'hE8:   v = 8'hBE;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic byte_t reset_value(idx_t idx);
        byte_t v;
        case (idx)
            8'hE0:   v = 8'h3C;
            8'hE2:   v = 8'h03;
            8'hE3:   v = 8'hFC;
            8'hE6:   v = 8'hDE;
            8'hE7:   v = 8'hFE;
            8'hE8:   v = 8'hBE;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode
    import sio_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h03F0,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h03F1
) (
    input  logic              port_en,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output io_strobe_t        strobe
);
    logic hit_idx;
    logic hit_dat;

    always_comb begin
        hit_idx        = port_en && (io_addr == INDEX_ADDR);
        hit_dat        = port_en && (io_addr == DATA_ADDR);
        strobe.idx_wr  = hit_idx && io_wr;
        strobe.data_wr = hit_dat && io_wr;
        strobe.data_rd = hit_dat && io_rd;
    end
endmodule

// File: rtl/sio_write_filter.sv
module sio_write_filter
    import sio_cfg_pkg::*;
(
    input  logic  data_wr,
    input  idx_t  idx,
    input  byte_t wdata,
    output logic  accept
);
    wp_class_e cls;

    always_comb begin
        cls = wp_class(idx);
        unique case (cls)
            WP_OPEN:   accept = data_wr;
            WP_KEYED:  accept = data_wr && (wdata == key_value(idx));
            default:   accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/sio_cfg_array.sv
module sio_cfg_array
    import sio_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  idx_t  idx,
    input  byte_t wdata,
    output byte_t rdata
);
    byte_t cells [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        localparam byte_t RST_V = reset_value(idx_t'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[g] <= RST_V;
            end else if (we && (idx == idx_t'(g))) begin
                cells[g] <= wdata;
            end
        end
    end

    assign rdata = cells[idx];
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h03F0,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h03F1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata
);
    io_strobe_t strobe;
    idx_t       idx_q;
    byte_t      sel_byte;
    logic       accept;

    sio_addr_decode #(
        .ADDR_W     (ADDR_W),
        .INDEX_ADDR (INDEX_ADDR),
        .DATA_ADDR  (DATA_ADDR)
    ) u_dec (
        .port_en (port_en),
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .strobe  (strobe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (strobe.idx_wr) begin
            idx_q <= idx_t'(io_wdata);
        end
    end

    sio_write_filter u_flt (
        .data_wr (strobe.data_wr),
        .idx     (idx_q),
        .wdata   (byte_t'(io_wdata)),
        .accept  (accept)
    );

    sio_cfg_array u_arr (
        .clk   (clk),
        .rst   (rst),
        .we    (accept),
        .idx   (idx_q),
        .wdata (byte_t'(io_wdata)),
        .rdata (sel_byte)
    );

    assign io_rdata = strobe.data_rd ? sel_byte : 8'hFF;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk
    import sio_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h03F0,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h03F1
) (
    input logic              clk,
    input logic              rst,
    input logic              port_en,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input idx_t              idx_q,
    input byte_t             sel_byte
);
    logic dat_wr;
    logic idx_wr;
    assign dat_wr = port_en && io_wr && (io_addr == DATA_ADDR);
    assign idx_wr = port_en && io_wr && (io_addr == INDEX_ADDR);

    assert_dis_read_ff_R7: assert property (@(posedge clk) disable iff (rst)
        (!port_en) |-> (io_rdata == 8'hFF));

    assert_stray_read_ff_R8: assert property (@(posedge clk) disable iff (rst)
        (io_addr != DATA_ADDR) |-> (io_rdata == 8'hFF));

    assert_index_load_R2: assert property (@(posedge clk) disable iff (rst)
        idx_wr |=> (idx_q == $past(io_wdata)));

    assert_index_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!idx_wr) |=> $stable(idx_q));

    assert_read_value_R3: assert property (@(posedge clk) disable iff (rst)
        (port_en && io_rd && (io_addr == DATA_ADDR)) |-> (io_rdata == sel_byte));

    assert_locked_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && wp_class(idx_q) == WP_LOCKED) |=> $stable(sel_byte));

    assert_keyed_reject_R5: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && wp_class(idx_q) == WP_KEYED && io_wdata != key_value(idx_q))
        |=> $stable(sel_byte));

    assert_keyed_accept_R5: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && wp_class(idx_q) == WP_KEYED && io_wdata == key_value(idx_q))
        |=> (sel_byte == $past(io_wdata)));

    assert_open_store_R6: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && wp_class(idx_q) == WP_OPEN) |=> (sel_byte == $past(io_wdata)));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
    .ADDR_W     (ADDR_W),
    .INDEX_ADDR (INDEX_ADDR),
    .DATA_ADDR  (DATA_ADDR)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .port_en  (port_en),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .idx_q    (idx_q),
    .sel_byte (sel_byte)
);

// File: tb/sio_cfg_port_tb_top.sv
module sio_cfg_port_tb_top;
    localparam logic [15:0] IA = 16'h03F0;
    localparam logic [15:0] DA = 16'h03F1;

    logic        clk = 1'b0;
    logic        rst;
    logic        port_en;
    logic [15:0] io_addr;
    logic        io_wr;
    logic        io_rd;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [256];
    logic [7:0] midx;

    always #4 clk = ~clk;

    sio_cfg_port dut_i (
        .clk(clk), .rst(rst), .port_en(port_en), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    function automatic logic [7:0] exp_reset(int i);
        case (i)
            8'hE0: return 8'h3C;
            8'hE2: return 8'h03;
            8'hE3: return 8'hFC;
            8'hE6: return 8'hDE;
            8'hE7: return 8'hFE;
            8'hE8: return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

    // 0 = dropped, 1 = stored
    function automatic bit exp_accept(logic [7:0] i, logic [7:0] v);
        if (i == 8'hE7) return v == 8'hFE;
        if (i == 8'hE8) return v == 8'hBE;
        if (i < 8'hE0) return 1'b0;
        if (i == 8'hE4 || i == 8'hE5 || i == 8'hF3 || i == 8'hF5 || i == 8'hF7) return 1'b0;
        if (i >= 8'hE9 && i <= 8'hED) return 1'b0;
        if (i >= 8'hF9 && i <= 8'hFB) return 1'b0;
        if (i >= 8'hFD) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        #1;
        io_wr = 1'b0; io_addr = 16'h0000;
        if (port_en) begin
            if (a == IA) midx = d;
            else if (a == DA && exp_accept(midx, d)) mdl[midx] = d;
        end
    endtask

    task automatic rd(logic [15:0] a, output logic [7:0] q);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #2;
        q = io_rdata;
        io_rd = 1'b0; io_addr = 16'h0000;
    endtask

    function automatic logic [7:0] exp_read(logic [15:0] a);
        if (!port_en || a != DA) return 8'hFF;
        return mdl[midx];
    endfunction

    task automatic rd_chk(string req, logic [15:0] a);
        logic [7:0] q;
        logic [7:0] e;
        e = exp_read(a);
        rd(a, q);
        check(req, q, e);
    endtask

    task automatic set_rd(string req, logic [7:0] i);
        wr(IA, i);
        rd_chk(req, DA);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] q;
        void'($urandom(32'd20240611));
        rst = 1'b1; port_en = 1'b0; io_addr = '0; io_wr = 1'b0;
        io_rd = 1'b0; io_wdata = '0;
        for (int i = 0; i < 256; i++) mdl[i] = exp_reset(i);
        midx = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R7: disabled after reset, reads give FF, writes ignored
        rd_chk("R7 disabled read", DA);
        wr(IA, 8'hE0);
        wr(DA, 8'h55);
        port_en = 1'b1;
        // R1: index still 0, byte 0 is 0
        rd_chk("R1 reset index", DA);
        // R1: full reset image
        for (int i = 0; i < 256; i++) set_rd("R1 reset image", 8'(i));
        wr(IA, 8'hE0);
        rd_chk("R7 disabled write dropped", DA);
        check("R7 model", mdl[8'hE0], 8'h3C);

        // R2/R3: index held over several reads
        wr(IA, 8'hE6);
        rd_chk("R2 index load", DA);
        rd_chk("R3 repeated read", DA);
        rd_chk("R3 read no side effect", DA);

        // R4 locked
        wr(IA, 8'h10); wr(DA, 8'hA5); rd_chk("R4 locked low range", DA);
        wr(IA, 8'hE4); wr(DA, 8'h11); rd_chk("R4 locked E4", DA);
        wr(IA, 8'hFB); wr(DA, 8'h22); rd_chk("R4 locked FB", DA);
        wr(IA, 8'hFF); wr(DA, 8'h33); rd_chk("R4 locked FF", DA);

        // R5 keyed
        wr(IA, 8'hE7); wr(DA, 8'h00); rd_chk("R5 E7 reject", DA);
        check("R5 E7 value", mdl[8'hE7], 8'hFE);
        wr(DA, 8'hFE); rd_chk("R5 E7 accept key", DA);
        wr(IA, 8'hE8); wr(DA, 8'hBF); rd_chk("R5 E8 reject", DA);
        wr(DA, 8'hBE); rd_chk("R5 E8 accept key", DA);

        // R6 open
        wr(IA, 8'hE0); wr(DA, 8'h5A); rd_chk("R6 open E0", DA);
        check("R6 model", mdl[8'hE0], 8'h5A);
        wr(IA, 8'hF2); wr(DA, 8'hC3); rd_chk("R6 open F2", DA);
        wr(IA, 8'hF4); wr(DA, 8'h00); wr(DA, 8'h7E); rd_chk("R6 open F4", DA);

        // R8 stray addresses
        wr(16'h03F2, 8'hE3); rd_chk("R8 stray index", DA);
        wr(16'h13F1, 8'h99); rd_chk("R8 stray data", DA);
        rd_chk("R8 stray read", IA);
        rd_chk("R8 stray read far", 16'h0060);

        // R7: disabled index write
        port_en = 1'b0;
        wr(IA, 8'hE2);
        port_en = 1'b1;
        rd_chk("R7 index unchanged", DA);

        // random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned op;
            logic [15:0] a;
            logic [7:0] d;
            op = $urandom_range(0, 9);
            if ($urandom_range(0, 15) == 0) port_en = ~port_en;
            case ($urandom_range(0, 5))
                0, 1: a = IA;
                2, 3, 4: a = DA;
                default: a = 16'($urandom);
            endcase
            if (op < 3) d = 8'($urandom_range(8'hE0, 8'hFF));
            else if (op < 5) d = (midx == 8'hE7) ? 8'hFE : 8'hBE;
            else d = 8'($urandom);
            if (op < 5) wr(a, d);
            else rd_chk("R3 random read", a);
        end
        port_en = 1'b1;
        for (int i = 8'hE0; i < 256; i++) set_rd("R6 final image", 8'(i));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule